// File: doc/BRIEF.md
# Run-Time Formatted Asynchronous Serial Transmitter

This block turns one character into an asynchronous serial frame. The frame shape is chosen separately for every character through three format inputs: the character width (five to nine bits), the parity policy (none, even or odd) and the number of stop bits (one or two). These give thirty usable shapes. The line rests high. A frame opens with a single low start bit and sends the character least significant bit first. The optional parity bit follows the character, and the frame closes with the high stop bits.

The block does not generate a bit rate. An external divider supplies a one-clock `baud_tick` pulse once per bit period, and the transmitter moves to the next bit only on that pulse. A request on `tx_start` captures the data word and all format fields together. The surrounding logic can therefore change them while the frame is on the wire. A request raised during the tick that ends the last stop bit begins the next frame at once, with no idle bit between the frames.

Top module: `uart_frame_tx`

## Requirements
- R1: An accepted request drives `tx_line` low (start bit) from the next clock edge and raises `tx_busy` at that edge.
- R2: After the start bit, the data bits go out least significant first. The count comes from `fmt_size`: 3'd0 gives 5 bits, 3'd1 gives 6, 3'd2 gives 7, 3'd3 gives 8 and 3'd7 gives 9.
- R3: `fmt_size` values 3'd4, 3'd5 and 3'd6 send 8 data bits.
- R4: When `fmt_parity` is 2'b10 (even) or 2'b11 (odd), one parity bit follows the last data bit. Its value is the XOR of the transmitted data bits only, inverted for odd.
- R5: When `fmt_parity` is 2'b00 or 2'b01, the frame has no parity bit.
- R6: `fmt_two_stop`=0 ends the frame with one high stop bit, and 1 ends it with two. While `tx_busy` is low, `tx_line` is high.
- R7: Data and format fields are captured at acceptance. Later changes to them, and `tx_start` pulses while a frame is in progress, do not alter the frame.
- R8: While busy, `tx_line` changes only on the clock edge that ends a cycle in which `baud_tick` was high. Each tick ends the current bit.
- R9: The edge that ends the tick cycle of the final stop bit drops `tx_busy` and raises `tx_done` for exactly one cycle.
- R10: A request held during that final tick starts the next frame at that same edge. `tx_busy` stays high and the start bit follows the last stop bit directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_data | input | 9 | Character; bits above the selected width are ignored |
| fmt_size | input | 3 | Character width code |
| fmt_parity | input | 2 | Parity policy code |
| fmt_two_stop | input | 1 | 1 selects two stop bits |
| tx_line | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | High while a frame is being sent |
| tx_done | output | 1 | One-cycle pulse after the last stop bit |

## Verification
Every width code, including the reserved ones, is sent with each parity policy. Data words with an even and an odd number of ones in the selected bits, together with set bits above the selected width, show whether parity covers exactly the sent bits. Frames are sent with the tick every cycle and with a slow tick, so the bench can see whether bits advance on the tick and not on a fixed count. One frame has its inputs changed and a second request raised during transmission, which checks that the fields are captured at acceptance. A request held over the final tick shows whether two frames join with no gap. Random words and formats cover the remaining combinations.

// File: rtl/uft_pkg.sv
package uft_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } uft_phase_e;

  localparam logic [1:0] PAR_EVEN = 2'b10;
  localparam logic [1:0] PAR_ODD  = 2'b11;
endpackage

// File: rtl/uft_format_decode.sv
module uft_format_decode #(
  parameter int SIZE_W = 3,
  parameter int PAR_W  = 2,
  parameter int CNT_W  = 4
) (
  input  logic [SIZE_W-1:0] size_code,
  input  logic [PAR_W-1:0]  par_code,
  output logic [CNT_W-1:0]  last_idx,
  output logic              par_en,
  output logic              par_odd
);
  // width code -> index of the last data bit (bits minus one)
  always_comb begin
    case (size_code)
      3'd0:    last_idx = CNT_W'(4);
      3'd1:    last_idx = CNT_W'(5);
      3'd2:    last_idx = CNT_W'(6);
      3'd7:    last_idx = CNT_W'(8);
      default: last_idx = CNT_W'(7);
    endcase
  end

  // only the top bit set enables parity; the low bit picks odd
  assign par_en  = par_code[PAR_W-1];
  assign par_odd = par_code[0];
endmodule

// File: rtl/uft_parity_gen.sv
module uft_parity_gen #(
  parameter int DATA_W = 9,
  parameter int CNT_W  = 4
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  last_idx,
  input  logic              odd,
  output logic              parity
);
  logic [DATA_W-1:0] keep;

  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_mask
      assign keep[i] = (CNT_W'(i) <= last_idx);
    end
  endgenerate

  assign parity = (^(data & keep)) ^ odd;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W = 9,
  parameter int SIZE_W = 3,
  parameter int PAR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [SIZE_W-1:0] fmt_size,
  input  logic [PAR_W-1:0]  fmt_parity,
  input  logic              fmt_two_stop,
  output logic              tx_line,
  output logic              tx_busy,
  output logic              tx_done
);
  import uft_pkg::*;

  localparam int CNT_W = $clog2(DATA_W) + 1;

  uft_phase_e        phase_q;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  last_q;
  logic              par_en_q;
  logic              par_bit_q;
  logic              two_stop_q;
  logic              stop_cnt_q;
  logic              line_q;
  logic              busy_q;
  logic              done_q;

  logic [CNT_W-1:0]  dec_last;
  logic              dec_par_en;
  logic              dec_par_odd;
  logic              gen_parity;
  logic              frame_end;
  logic              accept;

  uft_format_decode #(
    .SIZE_W (SIZE_W),
    .PAR_W  (PAR_W),
    .CNT_W  (CNT_W)
  ) u_decode (
    .size_code (fmt_size),
    .par_code  (fmt_parity),
    .last_idx  (dec_last),
    .par_en    (dec_par_en),
    .par_odd   (dec_par_odd)
  );

  uft_parity_gen #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_parity (
    .data     (tx_data),
    .last_idx (dec_last),
    .odd      (dec_par_odd),
    .parity   (gen_parity)
  );

  assign frame_end = busy_q && baud_tick && (phase_q == PH_STOP) &&
                     (stop_cnt_q == two_stop_q);
  assign accept    = tx_start && (!busy_q || frame_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      shift_q    <= '0;
      idx_q      <= '0;
      last_q     <= '0;
      par_en_q   <= 1'b0;
      par_bit_q  <= 1'b0;
      two_stop_q <= 1'b0;
      stop_cnt_q <= 1'b0;
      line_q     <= 1'b1;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= frame_end;
      if (accept) begin
        phase_q    <= PH_START;
        shift_q    <= tx_data;
        last_q     <= dec_last;
        par_en_q   <= dec_par_en;
        par_bit_q  <= gen_parity;
        two_stop_q <= fmt_two_stop;
        idx_q      <= '0;
        stop_cnt_q <= 1'b0;
        line_q     <= 1'b0;
        busy_q     <= 1'b1;
      end else if (frame_end) begin
        phase_q <= PH_IDLE;
        line_q  <= 1'b1;
        busy_q  <= 1'b0;
      end else if (busy_q && baud_tick) begin
        case (phase_q)
          PH_START: begin
            phase_q <= PH_DATA;
            line_q  <= shift_q[0];
            shift_q <= shift_q >> 1;
            idx_q   <= '0;
          end
          PH_DATA: begin
            if (idx_q == last_q) begin
              if (par_en_q) begin
                phase_q <= PH_PARITY;
                line_q  <= par_bit_q;
              end else begin
                phase_q    <= PH_STOP;
                line_q     <= 1'b1;
                stop_cnt_q <= 1'b0;
              end
            end else begin
              idx_q   <= idx_q + 1'b1;
              line_q  <= shift_q[0];
              shift_q <= shift_q >> 1;
            end
          end
          PH_PARITY: begin
            phase_q    <= PH_STOP;
            line_q     <= 1'b1;
            stop_cnt_q <= 1'b0;
          end
          PH_STOP: begin
            stop_cnt_q <= 1'b1;
          end
          default: begin
            phase_q <= PH_IDLE;
            line_q  <= 1'b1;
            busy_q  <= 1'b0;
          end
        endcase
      end
    end
  end

  assign tx_line = line_q;
  assign tx_busy = busy_q;
  assign tx_done = done_q;
endmodule

// File: rtl/uft_checker.sv
module uft_checker (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic tx_line,
  input logic tx_busy,
  input logic tx_done
);
  p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> !tx_line);

  p_idle_high_r6: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_line);

  p_tick_only_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && $past(tx_busy) && !$past(baud_tick)) |-> $stable(tx_line));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  p_done_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_busy) |-> tx_done);

  p_chain_start_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_busy) |-> !tx_line);
endmodule

bind uart_frame_tx uft_checker u_chk (.*);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       tx_start = 1'b0;
  logic [8:0] tx_data = '0;
  logic [2:0] fmt_size = '0;
  logic [1:0] fmt_parity = '0;
  logic       fmt_two_stop = 1'b0;
  logic       tx_line;
  logic       tx_busy;
  logic       tx_done;

  uart_frame_tx uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_start(tx_start),
    .tx_data(tx_data), .fmt_size(fmt_size), .fmt_parity(fmt_parity),
    .fmt_two_stop(fmt_two_stop), .tx_line(tx_line), .tx_busy(tx_busy),
    .tx_done(tx_done)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int tick_gap = 4;
  int done_cnt = 0;
  int stab_err = 0;
  bit cap[$];
  bit exp_q[$];
  logic prev_busy = 1'b0;
  logic prev_tick = 1'b0;
  logic prev_line = 1'b1;

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // tick source
  initial begin
    int cnt = 0;
    forever begin
      step();
      cnt++;
      if (cnt >= tick_gap) begin
        baud_tick = 1'b1;
        cnt = 0;
      end else begin
        baud_tick = 1'b0;
      end
    end
  end

  // port monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (baud_tick && tx_busy) cap.push_back(tx_line);
      if (tx_done) done_cnt++;
      if (prev_busy && tx_busy && !prev_tick && tx_line != prev_line) stab_err++;
    end
    prev_busy = tx_busy;
    prev_tick = baud_tick;
    prev_line = tx_line;
  end

  function automatic int width_of(input logic [2:0] s);
    case (s)
      3'd0: return 5;
      3'd1: return 6;
      3'd2: return 7;
      3'd3: return 8;
      3'd7: return 9;
      default: return 8;
    endcase
  endfunction

  task automatic append_exp(input logic [8:0] d, input logic [2:0] s,
                            input logic [1:0] p, input logic st);
    int n = width_of(s);
    bit x = 1'b0;
    exp_q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(d[i]);
      x ^= d[i];
    end
    if (p[1]) exp_q.push_back(x ^ p[0]);
    exp_q.push_back(1'b1);
    if (st) exp_q.push_back(1'b1);
  endtask

  task automatic check(input string tag, input bit ok, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic compare(input string tag, input int want_done);
    int mis = -1;
    if (cap.size() == exp_q.size())
      for (int i = 0; i < cap.size(); i++)
        if (mis < 0 && cap[i] != exp_q[i]) mis = i;
    if (cap.size() != exp_q.size())
      check(tag, 1'b0, "frame length", cap.size(), exp_q.size());
    else if (mis >= 0)
      check(tag, 1'b0, $sformatf("bit %0d value", mis), cap[mis], exp_q[mis]);
    else
      check(tag, 1'b1, "frame", 0, 0);
    check(tag, done_cnt == want_done, "done pulses", done_cnt, want_done);
  endtask

  task automatic send(input string tag, input logic [8:0] d, input logic [2:0] s,
                      input logic [1:0] p, input logic st, input bit disturb);
    while (tx_busy) step();
    step();
    cap.delete();
    exp_q.delete();
    done_cnt = 0;
    append_exp(d, s, p, st);
    tx_data = d; fmt_size = s; fmt_parity = p; fmt_two_stop = st;
    tx_start = 1'b1;
    step();
    tx_start = 1'b0;
    if (disturb) begin
      tx_data = ~d; fmt_size = s ^ 3'd5; fmt_parity = ~p; fmt_two_stop = ~st;
      step();
      tx_start = 1'b1;
      step();
      tx_start = 1'b0;
    end
    do step(); while (tx_busy);
    step();
    step();
    compare(tag, 1);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    bit gap_seen;
    logic [8:0] da;
    process::self().srandom(32'd7);
    repeat (4) step();
    rst = 1'b0;
    step();
    check("R6", tx_line === 1'b1, "idle line after reset", tx_line, 1);
    check("R9", tx_busy === 1'b0 && tx_done === 1'b0, "busy/done after reset",
          {tx_busy, tx_done}, 0);

    // R1 R2: every valid width, no parity
    send("R2", 9'h015, 3'd0, 2'b00, 1'b0, 0);
    send("R2", 9'h02A, 3'd1, 2'b00, 1'b0, 0);
    send("R2", 9'h05B, 3'd2, 2'b00, 1'b0, 0);
    send("R1", 9'h0C3, 3'd3, 2'b00, 1'b0, 0);
    send("R2", 9'h1A5, 3'd7, 2'b00, 1'b0, 0);
    // R3 reserved width codes
    send("R3", 9'h1F1, 3'd4, 2'b00, 1'b0, 0);
    send("R3", 9'h13C, 3'd5, 2'b10, 1'b0, 0);
    send("R3", 9'h1E7, 3'd6, 2'b11, 1'b1, 0);
    // R4 parity over sent bits only (upper bits set outside the width)
    send("R4", 9'h1E0, 3'd0, 2'b10, 1'b0, 0);
    send("R4", 9'h1E1, 3'd0, 2'b10, 1'b0, 0);
    send("R4", 9'h1E0, 3'd0, 2'b11, 1'b0, 0);
    send("R4", 9'h101, 3'd7, 2'b11, 1'b0, 0);
    send("R4", 9'h100, 3'd3, 2'b10, 1'b1, 0);
    // R5 reserved parity code and none
    send("R5", 9'h0B7, 3'd3, 2'b01, 1'b0, 0);
    send("R5", 9'h0B7, 3'd3, 2'b00, 1'b1, 0);
    // R6 two stop bits
    send("R6", 9'h055, 3'd2, 2'b10, 1'b1, 0);
    // R7 inputs changed and extra request during frame
    send("R7", 9'h0A6, 3'd3, 2'b10, 1'b0, 1);
    send("R7", 9'h133, 3'd7, 2'b11, 1'b1, 1);
    // R8 tick rate variations
    tick_gap = 1;
    send("R8", 9'h0C9, 3'd3, 2'b11, 1'b1, 0);
    tick_gap = 7;
    send("R8", 9'h06D, 3'd1, 2'b10, 1'b0, 0);
    tick_gap = 4;

    // R10 back-to-back frames
    while (tx_busy) step();
    step();
    cap.delete();
    exp_q.delete();
    done_cnt = 0;
    gap_seen = 1'b0;
    append_exp(9'h0F0, 3'd3, 2'b10, 1'b1);
    append_exp(9'h10F, 3'd7, 2'b11, 1'b0);
    tx_data = 9'h0F0; fmt_size = 3'd3; fmt_parity = 2'b10; fmt_two_stop = 1'b1;
    tx_start = 1'b1;
    step();
    tx_data = 9'h10F; fmt_size = 3'd7; fmt_parity = 2'b11; fmt_two_stop = 1'b0;
    while (!tx_done) begin
      step();
      if (!tx_busy) gap_seen = 1'b1;
    end
    tx_start = 1'b0;
    do step(); while (tx_busy);
    step();
    step();
    compare("R10", 2);
    check("R10", !gap_seen, "busy gap between chained frames", gap_seen, 0);

    // random mix
    for (int k = 0; k < 40; k++) begin
      da = 9'($urandom);
      send("R2 R3 R4 R5 R6", da, 3'($urandom), 2'($urandom), 1'($urandom), 0);
    end

    check("R8", stab_err == 0, "line moves without tick", stab_err, 0);
    summary();
  end
endmodule